// File: doc/BRIEF.md
# Sync Timing Analyzer with Glitch Rejection

This block watches the horizontal and vertical sync lines of a display input, or a single composite sync line, using a free-running reference clock. Each input is brought into the reference domain through two flops and then cleaned. Any level that does not last for a set number of reference clocks is dropped as noise. From the cleaned waveforms the block works out whether each sync is there, which level is its active pulse, and how many reference clocks one period takes.

In composite mode the cleaned line carries both kinds of pulse. A pulse whose active level lasts longer than half of the current line period is taken as vertical timing. That derived vertical signal is then measured like a separate vertical input. The line measurements that the long pulse disturbs are kept out of the horizontal results.

All results sit in one set of status registers. The registers are written together, with a one-cycle strobe. A second one-cycle flag marks the writes that changed a value.

Top module: `sync_timing_analyzer`

## Requirements
- R1: A level on a sync input is seen only after it has been held for GLITCH_CYC (default 2) consecutive reference clocks. A one-clock pulse changes no status output.
- R2: The period is the number of reference clocks between two successive rising edges of the cleaned signal.
- R3: The period field is 12 bits wide and saturates at 4095 when a period is longer than that.
- R4: The active-high flag is 1 when the high time within a period is strictly shorter than the low time. Otherwise, including a tie, it is 0.
- R5: A sync becomes present on the second rising edge after reset or after a loss. At the same moment its period and polarity are written.
- R6: When no rising edge arrives for `timeout_cycles` reference clocks, the status is written with present = 0, period = 0 and active-high = 0.
- R7: `stat_strobe` pulses for one cycle on each status write. The status fields change only in a cycle where the strobe is high.
- R8: `stat_changed` is high only together with `stat_strobe`, and only when at least one field differs from its previous value.
- R9: With `comp_mode` = 1, vertical timing is recognised when the active level of the composite line lasts longer than floor(line period / 2). The vertical period is the distance between successive recognitions. The vertical active-high flag equals the composite line's polarity.
- R10: With `comp_mode` = 1, the line measurement that contains a vertical pulse, and the one after it, do not update the horizontal status.
- R11: With `comp_mode` = 0, the vertical status is measured from `vsync_in` by the same rules as the horizontal one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| comp_mode | input | 1 | 1: `hsync_in` carries composite sync |
| timeout_cycles | input | 16 | Loss timeout in reference clocks (at least 2) |
| hsync_in | input | 1 | Horizontal or composite sync, asynchronous |
| vsync_in | input | 1 | Vertical sync, asynchronous |
| stat_h_period | output | 12 | Horizontal period in reference clocks |
| stat_h_active_high | output | 1 | Horizontal pulse is high-active |
| stat_h_present | output | 1 | Horizontal sync detected |
| stat_v_period | output | 12 | Vertical period in reference clocks |
| stat_v_active_high | output | 1 | Vertical pulse is high-active |
| stat_v_present | output | 1 | Vertical sync detected |
| stat_strobe | output | 1 | Status written this cycle |
| stat_changed | output | 1 | Status write changed a value |

## Verification
A bad edge detector or period counter shows up as a wrong period on the first strobe after two edges of the new pattern. That is within a handful of cycles of the second rising edge, because the path adds only two sync flops, the glitch filter, the meter stage and the status register. A wrong polarity count or a wrong saturation bound shows up in the same write. A broken timeout shows up only after the programmed window, as a present flag that never clears. A composite separator that mislabels a line shows up as a wrong vertical period, or as a horizontal value that jumps in the frame holding the long pulse.

// File: rtl/sync_pkg.sv
`timescale 1ns/1ps
package sync_pkg;
    localparam int PER_W = 12;

    typedef logic [PER_W-1:0] period_t;

    typedef struct packed {
        logic    present;
        logic    active_high;
        period_t period;
    } sync_stat_t;

    function automatic period_t sat_inc(period_t v);
        return (v == '1) ? v : period_t'(v + 1'b1);
    endfunction
endpackage

// File: rtl/sync_deglitch.sv
`timescale 1ns/1ps
module sync_deglitch #(
    parameter int GLITCH_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic clean_out
);
    localparam int CW = $clog2(GLITCH_CYC + 1);

    typedef struct packed {
        logic          meta;
        logic          sync;
        logic          filt;
        logic [CW-1:0] cnt;
    } dg_state_t;

    dg_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = raw_in;
        st_d.sync = st_q.meta;
        if (st_q.sync == st_q.filt) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == CW'(GLITCH_CYC - 1)) begin
            st_d.filt = st_q.sync;
            st_d.cnt  = '0;
        end else begin
            st_d.cnt = CW'(st_q.cnt + 1'b1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clean_out = st_q.filt;

    // a new filtered level must have been present on the synchronized input
    assert_filter_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.filt != $past(st_q.filt)) |-> ($past(st_q.sync) == st_q.filt));
endmodule

// File: rtl/sync_period_meter.sv
`timescale 1ns/1ps
module sync_period_meter
    import sync_pkg::*;
#(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lvl,
    input  logic [TO_W-1:0] timeout_cycles,
    output logic            meas_valid,
    output period_t         meas_period,
    output logic            meas_active_high,
    output logic            meas_lost
);
    typedef struct packed {
        logic            prev;
        logic            armed;
        period_t         per;
        period_t         hi;
        period_t         lo;
        logic [TO_W-1:0] to;
        logic            valid;
        logic            lost;
        period_t         out_per;
        logic            out_pol;
    } mt_state_t;

    mt_state_t st_d, st_q;
    logic            rise;
    logic [TO_W-1:0] to_next;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.lost  = 1'b0;
        st_d.prev  = lvl;
        rise       = lvl & ~st_q.prev;
        to_next    = (st_q.to == '1) ? st_q.to : TO_W'(st_q.to + 1'b1);
        if (rise) begin
            if (st_q.armed) begin
                st_d.valid   = 1'b1;
                st_d.out_per = st_q.per;
                st_d.out_pol = (st_q.hi < st_q.lo);
            end
            st_d.armed = 1'b1;
            st_d.per   = period_t'(1);
            st_d.hi    = period_t'(1);
            st_d.lo    = '0;
            st_d.to    = '0;
        end else begin
            st_d.per = sat_inc(st_q.per);
            if (lvl) st_d.hi = sat_inc(st_q.hi);
            else     st_d.lo = sat_inc(st_q.lo);
            st_d.to = to_next;
            if (st_q.armed && (to_next >= timeout_cycles)) begin
                st_d.lost  = 1'b1;
                st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign meas_valid       = st_q.valid;
    assign meas_period      = st_q.out_per;
    assign meas_active_high = st_q.out_pol;
    assign meas_lost        = st_q.lost;

    // rising edges are at least two clocks apart, so results never come back to back
    assert_no_adjacent_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |=> !meas_valid);
    assert_single_loss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        meas_lost |=> !meas_lost);
    assert_result_xor_loss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({meas_valid, meas_lost}));
endmodule

// File: rtl/csync_vsep.sv
`timescale 1ns/1ps
module csync_vsep
    import sync_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    lvl,
    input  logic    h_valid,
    input  period_t h_period,
    input  logic    h_active_high,
    input  logic    h_lost,
    output logic    v_derived,
    output logic    h_accept,
    output logic    ref_active_high
);
    typedef struct packed {
        period_t ref_half;
        logic    ref_pol;
        logic    ref_ok;
        period_t run;
        logic    vout;
        logic    vseen;
        logic    skip;
    } vs_state_t;

    vs_state_t st_d, st_q;
    logic      in_active;

    always_comb begin
        st_d      = st_q;
        in_active = (lvl == st_q.ref_pol);
        st_d.run  = in_active ? sat_inc(st_q.run) : '0;
        st_d.vout = in_active && st_q.ref_ok && (st_d.run > st_q.ref_half);
        if (st_d.vout) st_d.vseen = 1'b1;
        h_accept = h_valid && !st_q.vseen && !st_q.skip;
        if (h_valid) begin
            st_d.skip  = st_q.vseen;
            st_d.vseen = st_d.vout;
            if (h_accept) begin
                st_d.ref_half = period_t'(h_period >> 1);
                st_d.ref_pol  = h_active_high;
                st_d.ref_ok   = 1'b1;
            end
        end
        if (h_lost) begin
            st_d.ref_ok = 1'b0;
            st_d.vseen  = 1'b0;
            st_d.skip   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign v_derived       = st_q.vout;
    assign ref_active_high = st_q.ref_pol;

    // a line result is never taken while a vertical pulse is running
    assert_no_line_during_v_R10: assert property (@(posedge clk) disable iff (!rst_n)
        h_accept |-> !v_derived);
    assert_v_needs_reference_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(v_derived) |-> $past(st_q.ref_ok));
endmodule

// File: rtl/sync_timing_analyzer.sv
`timescale 1ns/1ps
module sync_timing_analyzer
    import sync_pkg::*;
#(
    parameter int GLITCH_CYC = 2,
    parameter int TO_W       = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            comp_mode,
    input  logic [TO_W-1:0] timeout_cycles,
    input  logic            hsync_in,
    input  logic            vsync_in,
    output logic [PER_W-1:0] stat_h_period,
    output logic            stat_h_active_high,
    output logic            stat_h_present,
    output logic [PER_W-1:0] stat_v_period,
    output logic            stat_v_active_high,
    output logic            stat_v_present,
    output logic            stat_strobe,
    output logic            stat_changed
);
    localparam int N_IN = 2;

    logic [N_IN-1:0] raw_vec, clean_vec;
    assign raw_vec = {vsync_in, hsync_in};

    for (genvar gi = 0; gi < N_IN; gi++) begin : g_cond
        sync_deglitch #(.GLITCH_CYC(GLITCH_CYC)) u_dg (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_in   (raw_vec[gi]),
            .clean_out(clean_vec[gi])
        );
    end

    logic    h_valid, h_pol, h_lost;
    period_t h_per;
    logic    v_valid, v_pol, v_lost;
    period_t v_per;
    logic    v_derived, h_accept, ref_pol, v_lvl;

    sync_period_meter #(.TO_W(TO_W)) u_hmeter (
        .clk(clk), .rst_n(rst_n), .lvl(clean_vec[0]), .timeout_cycles(timeout_cycles),
        .meas_valid(h_valid), .meas_period(h_per), .meas_active_high(h_pol), .meas_lost(h_lost)
    );

    csync_vsep u_vsep (
        .clk(clk), .rst_n(rst_n), .lvl(clean_vec[0]),
        .h_valid(h_valid), .h_period(h_per), .h_active_high(h_pol), .h_lost(h_lost),
        .v_derived(v_derived), .h_accept(h_accept), .ref_active_high(ref_pol)
    );

    assign v_lvl = comp_mode ? v_derived : clean_vec[1];

    sync_period_meter #(.TO_W(TO_W)) u_vmeter (
        .clk(clk), .rst_n(rst_n), .lvl(v_lvl), .timeout_cycles(timeout_cycles),
        .meas_valid(v_valid), .meas_period(v_per), .meas_active_high(v_pol), .meas_lost(v_lost)
    );

    typedef struct packed {
        sync_stat_t h;
        sync_stat_t v;
        logic       strobe;
        logic       changed;
    } st_state_t;

    st_state_t  st_d, st_q;
    logic       h_take;
    sync_stat_t h_new, v_new;

    always_comb begin
        h_take = comp_mode ? h_accept : h_valid;
        h_new  = st_q.h;
        v_new  = st_q.v;
        if (h_take)      h_new = '{present: 1'b1, active_high: h_pol, period: h_per};
        else if (h_lost) h_new = '0;
        if (v_valid)     v_new = '{present: 1'b1, active_high: (comp_mode ? ref_pol : v_pol), period: v_per};
        else if (v_lost) v_new = '0;
        st_d         = st_q;
        st_d.h       = h_new;
        st_d.v       = v_new;
        st_d.strobe  = h_take | h_lost | v_valid | v_lost;
        st_d.changed = (h_new != st_q.h) || (v_new != st_q.v);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_h_period      = st_q.h.period;
    assign stat_h_active_high = st_q.h.active_high;
    assign stat_h_present     = st_q.h.present;
    assign stat_v_period      = st_q.v.period;
    assign stat_v_active_high = st_q.v.active_high;
    assign stat_v_present     = st_q.v.present;
    assign stat_strobe        = st_q.strobe;
    assign stat_changed       = st_q.changed;

    assert_changed_with_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_changed |-> stat_strobe);
    assert_fields_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_strobe |-> ($stable(stat_h_period) && $stable(stat_v_period) &&
                          $stable(stat_h_present) && $stable(stat_v_present)));
    assert_h_loss_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_h_present) |-> (stat_h_period == '0 && !stat_h_active_high));
    assert_v_absent_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_v_present |-> (stat_v_period == '0));
endmodule

// File: tb/sync_timing_analyzer_tb.sv
`timescale 1ns/1ps
module sync_timing_analyzer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        comp_mode = 1'b0;
    logic [15:0] timeout_cycles = 16'd1000;
    logic        hsync_in = 1'b0;
    logic        vsync_in = 1'b0;
    logic [11:0] stat_h_period, stat_v_period;
    logic        stat_h_active_high, stat_h_present;
    logic        stat_v_active_high, stat_v_present;
    logic        stat_strobe, stat_changed;

    int total = 0;
    int bad   = 0;
    int chg_cnt = 0;
    int stb_cnt = 0;

    always #10 clk = ~clk;

    sync_timing_analyzer dut_i (
        .clk(clk), .rst_n(rst_n), .comp_mode(comp_mode), .timeout_cycles(timeout_cycles),
        .hsync_in(hsync_in), .vsync_in(vsync_in),
        .stat_h_period(stat_h_period), .stat_h_active_high(stat_h_active_high),
        .stat_h_present(stat_h_present), .stat_v_period(stat_v_period),
        .stat_v_active_high(stat_v_active_high), .stat_v_present(stat_v_present),
        .stat_strobe(stat_strobe), .stat_changed(stat_changed)
    );

    always @(negedge clk) begin
        if (stat_changed) chg_cnt++;
        if (stat_strobe)  stb_cnt++;
    end

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive_h(int per, int hi, int n);
        for (int i = 0; i < n; i++) begin
            hsync_in = 1'b1;
            repeat (hi) @(negedge clk);
            hsync_in = 1'b0;
            repeat (per - hi) @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        hsync_in = 1'b0;
        vsync_in = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int c0, s0;
        int pers[4];
        pers = '{12, 20, 33, 64};
        do_reset();
        // R7 reset state
        check("R7 reset h_period", int'(stat_h_period), 0);
        check("R7 reset v_period", int'(stat_v_period), 0);
        check("R5 reset h_present", int'(stat_h_present), 0);
        check("R7 reset strobe", int'(stat_strobe), 0);

        // R2 R4 R5 sweep of periods and duty
        foreach (pers[k]) begin
            for (int d = 0; d < 3; d++) begin
                int per, hi;
                per = pers[k];
                hi  = (d == 0) ? 2 : (d == 1) ? per / 2 : per - 2;
                drive_h(per, hi, 5);
                check("R2 h_period", int'(stat_h_period), per);
                check("R4 h_active_high", int'(stat_h_active_high), (hi < per - hi) ? 1 : 0);
                check("R5 h_present", int'(stat_h_present), 1);
                c0 = chg_cnt;
                s0 = stb_cnt;
                drive_h(per, hi, 4);
                check("R8 no change on repeat", chg_cnt - c0, 0);
                check("R7 strobe per period", (stb_cnt - s0 >= 3) ? 1 : 0, 1);
            end
        end

        // R6 loss of sync
        timeout_cycles = 16'd200;
        drive_h(40, 4, 5);
        check("R2 h_period before loss", int'(stat_h_period), 40);
        c0 = chg_cnt;
        hsync_in = 1'b0;
        repeat (300) @(negedge clk);
        check("R6 present after timeout", int'(stat_h_present), 0);
        check("R6 period after timeout", int'(stat_h_period), 0);
        check("R6 polarity after timeout", int'(stat_h_active_high), 0);
        check("R8 change flagged on loss", chg_cnt - c0, 1);

        // R1 single-clock pulses rejected
        c0 = chg_cnt;
        for (int g = 0; g < 10; g++) begin
            hsync_in = 1'b1;
            @(negedge clk);
            hsync_in = 1'b0;
            repeat (20) @(negedge clk);
        end
        check("R1 glitches keep absent", int'(stat_h_present), 0);
        check("R1 glitches no change", chg_cnt - c0, 0);

        // R1 two-clock pulses accepted, R5 reacquire
        drive_h(30, 2, 5);
        check("R1 two-clock pulse period", int'(stat_h_period), 30);
        check("R4 two-clock pulse polarity", int'(stat_h_active_high), 1);
        check("R5 reacquired", int'(stat_h_present), 1);

        // R1 glitches inside a running signal do not alter it
        drive_h(40, 20, 4);
        c0 = chg_cnt;
        for (int i = 0; i < 5; i++) begin
            hsync_in = 1'b1; repeat (10) @(negedge clk);
            hsync_in = 1'b0; @(negedge clk);
            hsync_in = 1'b1; repeat (9) @(negedge clk);
            hsync_in = 1'b0; repeat (8) @(negedge clk);
            hsync_in = 1'b1; @(negedge clk);
            hsync_in = 1'b0; repeat (11) @(negedge clk);
        end
        check("R1 glitched period", int'(stat_h_period), 40);
        check("R4 tie polarity", int'(stat_h_active_high), 0);
        check("R1 glitched no change", chg_cnt - c0, 0);

        // R3 saturation
        timeout_cycles = 16'd16000;
        drive_h(5000, 10, 3);
        check("R3 saturated period", int'(stat_h_period), 4095);
        check("R3 saturated polarity", int'(stat_h_active_high), 1);

        // R11 separate vertical input, active low
        timeout_cycles = 16'd1000;
        hsync_in = 1'b0;
        for (int i = 0; i < 5; i++) begin
            vsync_in = 1'b0; repeat (6) @(negedge clk);
            vsync_in = 1'b1; repeat (294) @(negedge clk);
        end
        check("R11 v_period", int'(stat_v_period), 300);
        check("R11 v_active_high", int'(stat_v_active_high), 0);
        check("R11 v_present", int'(stat_v_present), 1);

        // R9 R10 composite, active low, 10 lines per frame, last line long
        comp_mode = 1'b1;
        do_reset();
        for (int f = 0; f < 7; f++) begin
            if (f == 5) c0 = chg_cnt;
            for (int ln = 0; ln < 10; ln++) begin
                if (ln == 9) begin
                    hsync_in = 1'b0; repeat (30) @(negedge clk);
                    hsync_in = 1'b1; repeat (10) @(negedge clk);
                end else begin
                    hsync_in = 1'b0; repeat (4) @(negedge clk);
                    hsync_in = 1'b1; repeat (36) @(negedge clk);
                end
            end
        end
        check("R9 v_period composite", int'(stat_v_period), 400);
        check("R9 v_active_high composite", int'(stat_v_active_high), 0);
        check("R9 v_present composite", int'(stat_v_present), 1);
        check("R10 h_period composite", int'(stat_h_period), 40);
        check("R10 h_active_high composite", int'(stat_h_active_high), 0);
        check("R10 no change over frames", chg_cnt - c0, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule